// File: doc/BRIEF.md
# Dual-Channel Serial ADC Host Controller

This block is the host side of a link to a two-input 12-bit serial converter. It converts back to back without pause, and it needs no software. It drives chip select low. From the system clock it produces a divided serial clock, which rests high and starts each frame with a falling edge. One frame is exactly sixteen serial clock cycles. The first eight cycles carry an 8-bit control word to the device. Over all sixteen cycles the block shifts in 16 bits from the device. The last twelve of those bits are the conversion result. The first four must be zero.

The converter always converts the channel that was requested in the frame before. For this reason the controller picks the channel one frame ahead and keeps that pick. Each result leaves the block with the channel it was requested for, on a valid/ready port. No result is taken from the first frame after reset, because that frame has no request before it. Static inputs set four things: the reference bit, the single/dual bit, the power mode bits, and whether channels alternate or one channel stays fixed. Three parameters set timing: the clock divider, the minimum chip-select high time, and the extra wake-up wait. The wake-up wait is inserted when the power mode needs one.

Top module: `adc_dual_spi_host`

## Requirements
- R1: While reset is held and right after it, cs_n is 1, sclk is 1, mosi is 0 and res_valid is 0.
- R2: In each frame cs_n goes low once. sclk makes exactly 16 rising edges while cs_n is low, and the first edge after cs_n falls is a falling edge. With pwr_mode[0]=0, cs_n stays low for DIV*33 system cycles. Edges are DIV cycles apart, and sclk is 1 whenever cs_n is 1.
- R3: The control word is sent most significant bit first. Its bits are: bit7=0, bit6=0, bit5=0, bit4=ref_sel, bit3=dual_sel, bit2=channel, bit1..0=pwr_mode. The device reads these bits on rising edges 1 to 8, and mosi is 0 on rising edges 9 to 16. mosi changes only on falling sclk edges.
- R4: miso is sampled on each rising sclk edge, so 16 bits are taken per frame. The last 12, most significant bit first, appear on res_data.
- R5: With alt_mode=1, the channel sent is the inverse of the one sent in the frame before, and the first frame after reset sends 0. With alt_mode=0, the channel sent is fixed_ch. All static inputs are taken in the cycle that cs_n falls.
- R6: The first frame after reset gives no result. Every later frame gives exactly one result, and res_chan equals the channel that was sent in the frame before it.
- R7: res_err is 1 with a result exactly when any of the first four bits received in that frame is 1.
- R8: While res_valid=1 and res_ready=0, res_valid, res_data, res_chan and res_err hold their values. A new frame does not start while a result is pending.
- R9: Between frames, cs_n stays high for at least CS_GAP system cycles.
- R10: With pwr_mode[0]=1, the first sclk falling edge comes DIV+WAKE_CYC cycles after cs_n falls, so cs_n stays low for WAKE_CYC+DIV*33 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_mode | input | 1 | 1: alternate the channels; 0: use fixed_ch |
| fixed_ch | input | 1 | Channel to use when alt_mode is 0 |
| ref_sel | input | 1 | Reference select bit of the control word |
| dual_sel | input | 1 | Single/dual bit of the control word |
| pwr_mode | input | 2 | Power mode bits; bit 0 set adds the wake-up wait |
| cs_n | output | 1 | Chip select to the device, active low |
| sclk | output | 1 | Serial clock to the device, rests high |
| mosi | output | 1 | Control data to the device |
| miso | input | 1 | Conversion data from the device |
| res_valid | output | 1 | A result is waiting |
| res_ready | input | 1 | The consumer takes the result |
| res_data | output | 12 | Conversion result |
| res_chan | output | 1 | Channel the result belongs to |
| res_err | output | 1 | A leading bit of the result frame was non-zero |

## Verification
A result is due in the same clock cycle that cs_n rises, DIV cycles after the sixteenth rising sclk edge. It belongs to the frame that just ended, but it is tagged with the channel of the frame before that. The device model pushes the expected item into the queue at the rising edge of cs_n, and the monitor compares on the falling system clock edge that follows. The time cs_n stays low is measured in system cycles at each rising edge of cs_n and compared with DIV*33, or with WAKE_CYC+DIV*33 when the wake-up wait applies. The time cs_n stays high is measured at each falling edge of cs_n and compared with CS_GAP. Inputs change only while cs_n is high, so every frame takes its settings from one known set of inputs.

// File: rtl/adc_dual_spi_host.sv
module adc_dual_spi_host #(
  parameter int DIV      = 4,
  parameter int CS_GAP   = 4,
  parameter int WAKE_CYC = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_mode,
  input  logic        fixed_ch,
  input  logic        ref_sel,
  input  logic        dual_sel,
  input  logic [1:0]  pwr_mode,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [11:0] res_data,
  output logic        res_chan,
  output logic        res_err
);

  localparam int LONGEST = (DIV + WAKE_CYC > CS_GAP) ? DIV + WAKE_CYC : CS_GAP;
  localparam int CW = $clog2(LONGEST + 1);

  typedef enum logic [1:0] {S_GAP, S_LEAD, S_SHIFT, S_TAIL} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [4:0]  half;
  logic [7:0]  ctrl;
  logic [15:0] rx;
  logic        cur_ch, prev_ch, primed;

  wire tick    = (cnt == '0);
  wire next_ch = alt_mode ? ~cur_ch : fixed_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP;
      cnt <= CW'(CS_GAP - 1);
      half <= '0;
      ctrl <= '0;
      rx <= '0;
      cur_ch <= 1'b1;
      prev_ch <= 1'b0;
      primed <= 1'b0;
      cs_n <= 1'b1;
      sclk <= 1'b1;
      mosi <= 1'b0;
      res_valid <= 1'b0;
      res_data <= '0;
      res_chan <= 1'b0;
      res_err <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;
      case (st)
        S_GAP: if (tick && !res_valid) begin
          cs_n <= 1'b0;
          ctrl <= {3'b000, ref_sel, dual_sel, next_ch, pwr_mode};
          cur_ch <= next_ch;
          prev_ch <= cur_ch;
          cnt <= pwr_mode[0] ? CW'(DIV + WAKE_CYC - 1) : CW'(DIV - 1);
          st <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          sclk <= 1'b0;
          mosi <= ctrl[7];
          half <= 5'd1;
          cnt <= CW'(DIV - 1);
          st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          cnt <= CW'(DIV - 1);
          half <= half + 1'b1;
          if (half[0]) begin
            sclk <= 1'b1;
            rx <= {rx[14:0], miso};
            if (half == 5'd31) st <= S_TAIL;
          end else begin
            sclk <= 1'b0;
            mosi <= half[4] ? 1'b0 : ctrl[~half[3:1]];
          end
        end
        S_TAIL: if (tick) begin
          cs_n <= 1'b1;
          mosi <= 1'b0;
          cnt <= CW'(CS_GAP - 1);
          st <= S_GAP;
          primed <= 1'b1;
          if (primed) begin
            res_valid <= 1'b1;
            res_data <= rx[11:0];
            res_chan <= prev_ch;
            res_err <= |rx[15:12];
          end
        end
        default: st <= S_GAP;
      endcase
    end
  end

  a_r2_sclk_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk) && $past(!cs_n)) |-> $stable(mosi));

  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan) && $stable(res_err)));

  a_r8_no_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!res_valid));

  a_r6_result_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $rose(cs_n));

endmodule

// File: tb/adc_dual_spi_host_test.sv
module adc_dual_spi_host_test;
  localparam int DIV = 2, GAP = 3, WAKE = 7;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic alt_mode = 1, fixed_ch = 0, ref_sel = 0, dual_sel = 0;
  logic [1:0] pwr_mode = 2'b00;
  logic miso = 0, rdy = 0, hold = 0;
  logic cs_n, sclk, mosi, res_valid, res_chan, res_err;
  logic [11:0] res_data;

  adc_dual_spi_host #(.DIV(DIV), .CS_GAP(GAP), .WAKE_CYC(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode), .fixed_ch(fixed_ch),
    .ref_sel(ref_sel), .dual_sel(dual_sel), .pwr_mode(pwr_mode),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_ready(rdy), .res_data(res_data),
    .res_chan(res_chan), .res_err(res_err));

  int errors = 0, checks = 0, cyc = 0, frames = 0, rises = 0;
  logic [13:0] expq[$];
  logic [15:0] rxd;
  logic exp_last = 1'b1, prev_ch = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int n);
    return {(n % 5 == 3) ? 4'b0100 : 4'b0000, 12'((n * 291) ^ 2652)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    rdy <= hold ? 1'b0 : (cyc % 4 != 1);
  end

  always @(posedge sclk) if (!cs_n) rises++;

  initial begin : device
    int t_fall, t_rise, lead;
    logic exp_ch;
    logic [7:0] exp_ctrl;
    logic [15:0] w;
    t_rise = 0;
    forever begin
      @(negedge cs_n);
      t_fall = cyc;
      if (frames > 0) chk(t_fall - t_rise >= GAP, "R9", "cs high cycles", t_fall - t_rise, GAP);
      exp_ch = alt_mode ? ~exp_last : fixed_ch;
      exp_last = exp_ch;
      exp_ctrl = {3'b000, ref_sel, dual_sel, exp_ch, pwr_mode};
      lead = pwr_mode[0] ? DIV + WAKE : DIV;
      w = word_of(frames);
      rises = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge sclk) miso = w[15-i];
        @(posedge sclk) rxd[15-i] = mosi;
      end
      @(posedge cs_n);
      t_rise = cyc;
      chk(rxd[10] == exp_ch, "R5", "channel bit", rxd[10], exp_ch);
      chk(rxd[15:8] == exp_ctrl, "R3", "control word", rxd[15:8], exp_ctrl);
      chk(rxd[7:0] == 8'h00, "R3", "trailing mosi", rxd[7:0], 0);
      chk(rises == 16, "R2", "rising edges", rises, 16);
      chk(t_rise - t_fall == lead + 32 * DIV, pwr_mode[0] ? "R10" : "R2",
          "cs low cycles", t_rise - t_fall, lead + 32 * DIV);
      if (frames > 0) expq.push_back({prev_ch, w[15:12] != 4'b0, w[11:0]});
      prev_ch = exp_ch;
      frames++;
    end
  end

  logic lv = 0, lr = 0, lc = 0, le = 0;
  logic [11:0] ld = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lv && !lr)
        chk(res_valid && res_data == ld && res_chan == lc && res_err == le, "R8",
            "held result", res_data, ld);
      if (res_valid && rdy) begin
        if (expq.size() == 0) chk(1'b0, "R6", "unexpected result", res_data, 0);
        else begin
          logic [13:0] e;
          e = expq.pop_front();
          chk(res_chan == e[13], "R6", "channel tag", res_chan, e[13]);
          chk(res_err == e[12], "R7", "error flag", res_err, e[12]);
          chk(res_data == e[11:0], "R4", "result data", res_data, e[11:0]);
        end
      end
    end
    lv = res_valid; lr = rdy; ld = res_data; lc = res_chan; le = res_err;
  end

  task automatic run(input int k, input bit a, input bit f, input bit r, input bit d, input logic [1:0] p);
    int target;
    @(negedge clk);
    while (!cs_n) @(negedge clk);
    alt_mode = a; fixed_ch = f; ref_sel = r; dual_sel = d; pwr_mode = p;
    target = frames + k;
    while (frames < target) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit stayed;
    repeat (4) @(negedge clk);
    chk(cs_n && sclk && !mosi && !res_valid, "R1", "in reset", {cs_n, sclk, mosi, res_valid}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && sclk && !mosi && !res_valid, "R1", "after reset", {cs_n, sclk, mosi, res_valid}, 4'b1100);
    run(6, 1, 0, 0, 0, 2'b00);
    run(4, 0, 1, 1, 1, 2'b10);
    run(3, 1, 0, 0, 1, 2'b11);
    run(3, 0, 0, 1, 0, 2'b01);
    hold = 1;
    repeat (2) @(negedge clk);
    while (!res_valid) @(negedge clk);
    stayed = 1;
    repeat (100) begin
      @(negedge clk);
      if (!cs_n || !res_valid) stayed = 0;
    end
    chk(stayed, "R8", "no frame while pending", stayed, 1);
    hold = 0;
    run(4, 1, 0, 0, 0, 2'b00);
    repeat (400) begin
      @(negedge clk);
      if (expq.size() == 0 && !res_valid) break;
    end
    chk(expq.size() == 0, "R6", "results drained", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule